// File: doc/BRIEF.md
# Sobel Edge Magnitude Stage

This block turns a 3x3 neighbourhood of 12-bit luminance samples into one 8-bit pixel that shows edge strength: a flat area comes out white (255) and a strong edge comes out dark, down to 0. The window former upstream presents the eight neighbours of the current pixel. The centre sample is not needed by the gradient, so it has no port. One window is accepted per clock.

Inside, one Sobel kernel module is built twice. One copy gives the horizontal gradient (right column minus left column) and the other gives the vertical gradient (bottom row minus top row), each with weights 1, 2, 1. The two gradients are squared and added. The sum is scaled down by 256 and clamped to an 18-bit ceiling. It is then truncated to a 13-bit code. That code is mapped to the output pixel by an inverted square-root function, which also halves the root. The four register stages share a single advance condition. Input and output are valid/ready streams. When the consumer stalls, the whole pipeline freezes: `in_ready` drops in the same cycle as the stall and stays low until the held result is taken. No result is dropped, duplicated or reordered.

Top module: `sobel_edge_pipe`

## Requirements
- R1: The horizontal gradient is (tap_ne + 2·tap_e + tap_se) − (tap_nw + 2·tap_w + tap_sw). The vertical gradient is (tap_sw + 2·tap_s + tap_se) − (tap_nw + 2·tap_n + tap_ne). For example, a window with only tap_e = 2048 gives pixel 127, and one with only tap_ne = 2048 gives pixel 165.
- R2: Let Q be the sum of the two squared gradients, and A = min(floor(Q/256), 262143) / 32, rounded down (a 13-bit code). Then out_pix = 255 − floor(floor(sqrt(32·A))/2). A vertical step from 2400 to 3520 across the window gives 115.
- R3: When floor(Q/256) exceeds 262143, the code A saturates at 8191 and the pixel is 0.
- R4: A window whose eight taps are all equal produces 255.
- R5: A window accepted at a clock edge with no stall appears on out_valid after the fourth edge, counting the accepting edge. Results leave in acceptance order, one per accepted window.
- R6: While out_valid is high and out_ready is low, in_ready is low, and out_valid and out_pix hold their values at the next edge. in_ready equals (not out_valid) or out_ready.
- R7: During and just after reset, out_valid is low and in_ready is high.
- R8: A cycle with in_valid low or in_ready low creates no result; no output appears without an accepted window.
- R9: Mirroring a window left-right or turning a vertical step into a horizontal one leaves the pixel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Window taps are valid |
| in_ready | output | 1 | Block accepts a window this cycle |
| tap_nw | input | 12 | Top-left sample |
| tap_n | input | 12 | Top-centre sample |
| tap_ne | input | 12 | Top-right sample |
| tap_w | input | 12 | Middle-left sample |
| tap_e | input | 12 | Middle-right sample |
| tap_sw | input | 12 | Bottom-left sample |
| tap_s | input | 12 | Bottom-centre sample |
| tap_se | input | 12 | Bottom-right sample |
| out_valid | output | 1 | out_pix holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_pix | output | 8 | Edge visualisation pixel |

## Verification
A consumer stall can arrive in the same cycle as a new window is offered. It can also arrive in the same cycle as a saturated or flat result reaches the output. Every one of the 256 windows whose taps are all 0 or all 4095 is sent twice: once with out_ready held high, and once with out_ready randomly low about 40% of the time. A further random set is sent under the same random stalls. Each pixel is compared in order against an arithmetic model kept in the bench. Each stalled cycle is also judged on its own: the held output must not change and in_ready must be low.

// File: rtl/sobel_pkg.sv
package sobel_pkg;
  localparam int NUM_TAPS = 8;
  localparam int NUM_DIRS = 2;

  typedef enum int {
    TAP_NW = 0, TAP_N = 1, TAP_NE = 2, TAP_W = 3,
    TAP_E  = 4, TAP_SW = 5, TAP_S = 6, TAP_SE = 7
  } tap_pos_e;

  // Kernel slot k: 0..2 = positive side (corner, middle, corner),
  // 3..5 = negative side (corner, middle, corner). Direction 0 is horizontal.
  function automatic int kernel_tap(input int dir, input int k);
    tap_pos_e p;
    if (dir == 0) begin
      case (k)
        0: p = TAP_NE;  1: p = TAP_E;  2: p = TAP_SE;
        3: p = TAP_NW;  4: p = TAP_W;  default: p = TAP_SW;
      endcase
    end else begin
      case (k)
        0: p = TAP_SW;  1: p = TAP_S;  2: p = TAP_SE;
        3: p = TAP_NW;  4: p = TAP_N;  default: p = TAP_NE;
      endcase
    end
    return int'(p);
  endfunction
endpackage

// File: rtl/sobel_kernel.sv
module sobel_kernel #(
  parameter int LW = 12,
  parameter int SW = LW + 3
) (
  input  logic [LW-1:0]        pa,
  input  logic [LW-1:0]        pm,
  input  logic [LW-1:0]        pb,
  input  logic [LW-1:0]        na,
  input  logic [LW-1:0]        nm,
  input  logic [LW-1:0]        nb,
  output logic signed [SW-1:0] grad
);
  logic [LW+1:0] pos_sum;
  logic [LW+1:0] neg_sum;

  always_comb begin
    pos_sum = (LW+2)'(pa) + {1'b0, pm, 1'b0} + (LW+2)'(pb);
    neg_sum = (LW+2)'(na) + {1'b0, nm, 1'b0} + (LW+2)'(nb);
    grad    = signed'(SW'(pos_sum)) - signed'(SW'(neg_sum));
  end
endmodule

// File: rtl/sobel_invroot.sv
module sobel_invroot #(
  parameter int ADDR_W  = 13,
  parameter int TRUNC_W = 5,
  parameter int PIX_W   = 8
) (
  input  logic [ADDR_W-1:0] code,
  output logic [PIX_W-1:0]  pix
);
  localparam int X_W     = ADDR_W + TRUNC_W;
  localparam int ROOT_W  = (X_W + 1) / 2;
  localparam int SQR_W   = 2 * ROOT_W;
  localparam int PIX_MAX = (1 << PIX_W) - 1;

  logic [SQR_W-1:0]  x;
  logic [ROOT_W-1:0] root;
  logic [ROOT_W-1:0] trial;
  logic [ROOT_W-1:0] half;

  // Digit-by-digit floor square root of code*2^TRUNC_W, then halve and invert.
  always_comb begin
    x    = SQR_W'({code, {TRUNC_W{1'b0}}});
    root = '0;
    for (int i = ROOT_W - 1; i >= 0; i--) begin
      trial = root | (ROOT_W'(1) << i);
      if (SQR_W'(trial) * SQR_W'(trial) <= x) root = trial;
    end
    half = root >> 1;
    if (int'(half) > PIX_MAX) pix = '0;
    else                      pix = PIX_W'(PIX_MAX - int'(half));
  end
endmodule

// File: rtl/sobel_edge_pipe.sv
module sobel_edge_pipe
  import sobel_pkg::*;
#(
  parameter int LUMA_W    = 12,
  parameter int DROP_BITS = 8,
  parameter int SAT_W     = 18,
  parameter int ADDR_W    = 13,
  parameter int PIX_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [LUMA_W-1:0] tap_nw,
  input  logic [LUMA_W-1:0] tap_n,
  input  logic [LUMA_W-1:0] tap_ne,
  input  logic [LUMA_W-1:0] tap_w,
  input  logic [LUMA_W-1:0] tap_e,
  input  logic [LUMA_W-1:0] tap_sw,
  input  logic [LUMA_W-1:0] tap_s,
  input  logic [LUMA_W-1:0] tap_se,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PIX_W-1:0]  out_pix
);
  localparam int SUM_W   = LUMA_W + 3;
  localparam int MUL_W   = 2 * SUM_W;
  localparam int SQ_W    = 2 * SUM_W - 1;
  localparam int TRUNC_W = SAT_W - ADDR_W;
  localparam logic [SQ_W-1:0] SAT_LIM = SQ_W'((64'd1 << SAT_W) - 64'd1);

  logic [LUMA_W-1:0]       taps [NUM_TAPS];
  logic signed [SUM_W-1:0] grad [NUM_DIRS];
  logic signed [SUM_W-1:0] g_q  [NUM_DIRS];
  logic signed [MUL_W-1:0] g_ext[NUM_DIRS];
  logic signed [MUL_W-1:0] g_sq [NUM_DIRS];
  logic [SQ_W-1:0]         sq_c, sq_q;
  logic [ADDR_W-1:0]       addr_c, addr_q;
  logic [PIX_W-1:0]        pix_c, pix_q;
  logic                    v1, v2, v3, v4;
  logic                    adv;

  assign taps[TAP_NW] = tap_nw;
  assign taps[TAP_N]  = tap_n;
  assign taps[TAP_NE] = tap_ne;
  assign taps[TAP_W]  = tap_w;
  assign taps[TAP_E]  = tap_e;
  assign taps[TAP_SW] = tap_sw;
  assign taps[TAP_S]  = tap_s;
  assign taps[TAP_SE] = tap_se;

  // One kernel per direction; only the tap routing differs.
  for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
    sobel_kernel #(.LW(LUMA_W), .SW(SUM_W)) u_kern (
      .pa  (taps[kernel_tap(d, 0)]),
      .pm  (taps[kernel_tap(d, 1)]),
      .pb  (taps[kernel_tap(d, 2)]),
      .na  (taps[kernel_tap(d, 3)]),
      .nm  (taps[kernel_tap(d, 4)]),
      .nb  (taps[kernel_tap(d, 5)]),
      .grad(grad[d])
    );
  end

  // Whole pipeline advances together; a held output freezes every stage.
  assign adv       = !v4 || out_ready;
  assign in_ready  = adv;
  assign out_valid = v4;
  assign out_pix   = pix_q;

  always_comb begin
    sq_c = '0;
    for (int d = 0; d < NUM_DIRS; d++) begin
      g_ext[d] = MUL_W'(g_q[d]);
      g_sq[d]  = g_ext[d] * g_ext[d];
      sq_c     = sq_c + SQ_W'(g_sq[d]);
    end
  end

  always_comb begin
    if ((sq_q >> DROP_BITS) > SAT_LIM) addr_c = '1;
    else                               addr_c = ADDR_W'(sq_q >> (DROP_BITS + TRUNC_W));
  end

  sobel_invroot #(.ADDR_W(ADDR_W), .TRUNC_W(TRUNC_W), .PIX_W(PIX_W)) u_root (
    .code(addr_q),
    .pix (pix_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
      v4 <= 1'b0;
    end else if (adv) begin
      v1 <= in_valid;
      v2 <= v1;
      v3 <= v2;
      v4 <= v3;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      for (int d = 0; d < NUM_DIRS; d++) g_q[d] <= grad[d];
      sq_q   <= sq_c;
      addr_q <= addr_c;
      pix_q  <= pix_c;
    end
  end
endmodule

// File: rtl/sobel_edge_chk.sv
module sobel_edge_chk #(
  parameter int SQ_W      = 29,
  parameter int DROP_BITS = 8,
  parameter int SAT_W     = 18,
  parameter int ADDR_W    = 13,
  parameter int PIX_W     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [PIX_W-1:0]  out_pix,
  input logic              v2,
  input logic              v3,
  input logic [SQ_W-1:0]   sq_q,
  input logic [ADDR_W-1:0] addr_q
);
  localparam logic [SQ_W-1:0] SAT_LIM = SQ_W'((64'd1 << SAT_W) - 64'd1);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pix));

  p_stall_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_idle_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_no_phantom_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && !v3 |=> !out_valid);

  p_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && v2 && ((sq_q >> DROP_BITS) > SAT_LIM) |=> (addr_q == '1));
endmodule

bind sobel_edge_pipe sobel_edge_chk #(
  .SQ_W(SQ_W), .DROP_BITS(DROP_BITS), .SAT_W(SAT_W), .ADDR_W(ADDR_W), .PIX_W(PIX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_pix(out_pix), .v2(v2), .v3(v3),
  .sq_q(sq_q), .addr_q(addr_q)
);

// File: tb/sim_sobel_edge_pipe.sv
`timescale 1ns/1ps
module sim_sobel_edge_pipe;
  localparam int LW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic in_ready, out_valid;
  logic [7:0] out_pix;
  logic [LW-1:0] t [8];

  int checks = 0;
  int errors = 0;
  int pops = 0;
  int ready_pct = 100;
  bit done = 0;
  bit held_valid = 0;
  logic [7:0] held_pix = '0;
  int exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  initial for (int k = 0; k < 8; k++) t[k] = '0;

  sobel_edge_pipe u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .tap_nw(t[0]), .tap_n(t[1]), .tap_ne(t[2]), .tap_w(t[3]),
    .tap_e(t[4]), .tap_sw(t[5]), .tap_s(t[6]), .tap_se(t[7]),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
  );

  // Tap order: 0 nw, 1 n, 2 ne, 3 w, 4 e, 5 sw, 6 s, 7 se.
  function automatic int model(input int v[8]);
    longint gx, gy, q, a, x, r;
    gx = (v[2] + 2*v[4] + v[7]) - (v[0] + 2*v[3] + v[5]);
    gy = (v[5] + 2*v[6] + v[7]) - (v[0] + 2*v[1] + v[2]);
    q = gx*gx + gy*gy;
    a = q / 256;
    if (a > 262143) a = 262143;
    a = a / 32;
    x = a * 32;
    r = 0;
    while ((r+1)*(r+1) <= x) r++;
    return 255 - int'(r / 2);
  endfunction

  task automatic check(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic step(input bit drive, input int v[8], input string tag,
                      input int expv, output bit taken);
    int e;
    string s;
    @(negedge clk);
    out_ready = ($urandom_range(99) < ready_pct);
    in_valid  = drive;
    for (int k = 0; k < 8; k++) t[k] = LW'(v[k]);
    #1;
    if (held_valid) check("R6 held output", out_valid ? int'(out_pix) : -1, int'(held_pix));
    if (out_valid && !out_ready) check("R6 in_ready low in stall", int'(in_ready), 0);
    held_valid = out_valid && !out_ready;
    held_pix   = out_pix;
    if (out_valid && out_ready) begin
      pops++;
      if (exp_q.size() == 0) check("R8 unexpected output", 1, 0);
      else begin
        e = exp_q.pop_front();
        s = tag_q.pop_front();
        check(s, int'(out_pix), e);
      end
    end
    taken = drive && in_ready;
    if (taken) begin
      exp_q.push_back(expv);
      tag_q.push_back(tag);
    end
  endtask

  task automatic send(input int v[8], input string tag, input int expv);
    bit tk;
    do step(1'b1, v, tag, expv, tk); while (!tk);
  endtask

  task automatic idle(input int n);
    int z[8];
    bit tk;
    for (int k = 0; k < 8; k++) z[k] = 0;
    repeat (n) step(1'b0, z, "", 0, tk);
  endtask

  task automatic send_model(input int v[8], input string tag);
    send(v, tag, model(v));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    int v[8];
    int n, p0;
    bit tk;

    repeat (3) @(negedge clk);
    #1;
    check("R7 out_valid in reset", int'(out_valid), 0);
    check("R7 in_ready in reset", int'(in_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R7 out_valid after reset", int'(out_valid), 0);
    check("R7 in_ready after reset", int'(in_ready), 1);

    // R1: single-tap windows expose kernel routing and weights
    v = '{0, 0, 0, 0, 2048, 0, 0, 0};    send(v, "R1 tap_e only", 127);
    v = '{0, 2048, 0, 0, 0, 0, 0, 0};    send(v, "R1 tap_n only", 127);
    v = '{0, 0, 2048, 0, 0, 0, 0, 0};    send(v, "R1 tap_ne only", 165);
    v = '{0, 0, 0, 0, 0, 0, 2048, 0};    send(v, "R1 tap_s only", 127);
    // R2: vertical step 2400 -> 3520
    v = '{2400, 2960, 3520, 2400, 3520, 2400, 2960, 3520}; send(v, "R2 vertical step", 115);
    // R9: mirrored and rotated steps
    v = '{3520, 2960, 2400, 3520, 2400, 3520, 2960, 2400}; send(v, "R9 mirrored step", 115);
    v = '{2400, 2400, 2400, 2960, 2960, 3520, 3520, 3520}; send(v, "R9 rotated step", 115);
    // R3: saturation
    v = '{0, 0, 4095, 0, 4095, 0, 4095, 4095}; send(v, "R3 saturated", 0);
    // R4: flat windows
    v = '{1000, 1000, 1000, 1000, 1000, 1000, 1000, 1000}; send(v, "R4 flat mid", 255);
    v = '{4095, 4095, 4095, 4095, 4095, 4095, 4095, 4095}; send(v, "R4 flat max", 255);
    v = '{0, 0, 0, 0, 0, 0, 0, 0};                         send(v, "R4 flat zero", 255);
    idle(8);

    // R5: latency of a lone window
    p0 = pops;
    v = '{0, 0, 0, 0, 2048, 0, 0, 0};
    step(1'b1, v, "R5 latency value", 127, tk);
    check("R5 lone window accepted", int'(tk), 1);
    n = 0;
    while (pops == p0 && n < 20) begin
      idle(1);
      n++;
    end
    check("R5 latency in edges", n, 4);

    // R8: idle input yields nothing
    idle(12);
    check("R8 queue drained", exp_q.size(), 0);

    // Exhaustive extreme-tap sweep, no stalls, then with stalls (R2, R3, R4, R6)
    for (int m = 0; m < 256; m++) begin
      for (int k = 0; k < 8; k++) v[k] = m[k] ? 4095 : 0;
      send_model(v, "R2 extreme sweep");
    end
    ready_pct = 60;
    for (int m = 0; m < 256; m++) begin
      for (int k = 0; k < 8; k++) v[k] = m[k] ? 4095 : 0;
      send_model(v, "R6 extreme sweep stalled");
    end
    for (int i = 0; i < 1500; i++) begin
      for (int k = 0; k < 8; k++) v[k] = int'($urandom_range(4095));
      send_model(v, "R2 random stalled");
    end
    ready_pct = 100;
    idle(12);
    check("R5 every accepted window returned in order", exp_q.size(), 0);

    done = 1;
    report();
    $finish;
  end
endmodule